// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between a clocked request port and an external asynchronous static RAM of 128K bytes. Each request is a single byte read or write. The block drives the address, the data and the four memory strobes in a fixed order, and it holds each strobe for a cycle count that is derived from the clock period and the memory's nanosecond timing limits. The memory selects itself only when the active-low enable is low and the active-high enable is high. Its output enable and write enable are both active low.

A request is taken when `reqValid` is high in a cycle where `reqReady` is high. Every transaction runs the same way. First comes one setup cycle, in which the chip is selected and the address is stable. Then comes a strobe window, with write enable low for a write or output enable low for a read. Last comes a recovery period, in which the chip is deselected. Read data is sampled on the clock edge that ends the output-enable window and is returned with a one-cycle valid pulse. During a write, output enable stays high and the data driver turns on only after the memory's output-float time has passed. The data bus is split into `memDout`, `memDin` and `memDoutEn`, which drive the pad-level tristate buffer.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: A synchronous active-high `rst` forces the following on the next clock edge, even in the middle of a transaction: memCe1N=1, memCe2=0, memWeN=1, memOeN=1, memDoutEn=0, rspValid=0, memAddr=0 and reqReady=1. A write cut short by reset has no effect on the memory.
- R2: The two chip enables are complementary in every cycle (memCe1N == !memCe2). The chip is selected (memCe1N=0, memCe2=1) exactly during the setup cycle and the strobe window.
- R3: memWeN and memOeN are never low in the same cycle, and either one is low only while the chip is selected.
- R4: A write has one setup cycle with WE and OE high. WE then stays low for WR_CYC consecutive cycles, where WR_CYC = max(ceil(tPWE/T), ceil(tAW/T)-1, ceil(tHZWE/T)+ceil(tSD/T)). The defaults are T=10, tPWE=10, tAW=12, tHZWE=7 and tSD=8, which give WR_CYC=2. OE stays high for the whole write.
- R5: The data driver behaves as follows during a write. memDoutEn is 0 for the first HZ_CYC=ceil(tHZWE/T) cycles with WE low (1 by default). It is 1 for the rest of the WE pulse and for the first cycle after WE rises. It is 0 at every other time and never 1 while OE is low. While memDoutEn is on, memDout carries the write data unchanged.
- R6: A read has one setup cycle and then OE low for RD_CYC = max(ceil(tAA/T)-1, ceil(tDOE/T), 1) cycles. The defaults tAA=15 and tDOE=7 give RD_CYC=1. memDin is sampled on the edge that ends the last OE-low cycle. rspValid is high for exactly the next cycle, with rspData equal to that sample.
- R7: reqReady is high exactly when the block is idle. A request is accepted on an edge where reqValid and reqReady are both high. A reqValid asserted while reqReady is low has no effect on any pin.
- R8: memAddr carries the accepted address from the setup cycle until the next request is accepted. It does not change while the chip is selected.
- R9: After the strobe window the chip is deselected, with WE and OE high, for TURNAROUND cycles (1 by default) before reqReady returns. A write is therefore busy for 1+WR_CYC+TURNAROUND cycles and a read for 1+RD_CYC+TURNAROUND cycles.
- R10: rspValid is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Request byte address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | Block idle, request can be taken |
| rspValid | output | 1 | One-cycle read data valid pulse |
| rspData | output | 8 | Captured read data |
| memAddr | output | 17 | Memory address bus |
| memDout | output | 8 | Data driven toward the memory |
| memDin | input | 8 | Data received from the memory |
| memDoutEn | output | 1 | Enable of the data bus tristate driver |
| memCe1N | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |

## Verification
The assertions check the pin-level invariants on every cycle. These are enable polarity, the exclusion of WE and OE and of the driver and OE, address and data stability while the chip is selected or being driven, the driver staying off in the first WE-low cycle, quiet pins while ready, and the placement of the read valid pulse. Only the bench scenarios can show the exact strobe lengths, the recovery count, the right byte being captured at the right edge, a write landing in memory and reading back, requests made while busy being ignored, and a write cut short by reset leaving memory untouched.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // latch request address and data
    logic capture;  // sample memory read data
    logic ceOn;     // chip selected
    logic weOn;     // write enable asserted
    logic oeOn;     // output enable asserted
    logic drvOn;    // data driver on
  } seqCtl_t;

  function automatic int nsToCycles(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_strobe_pkg::*;
#(
  parameter int WR_CYC   = 2,
  parameter int RD_CYC   = 1,
  parameter int HZ_CYC   = 1,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output seqCtl_t ctl
);

  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_AT     = CNT_W'(HZ_CYC);

  seqState_t        state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic             isWrite, nxtWrite;
  logic             lastStrobe;
  logic             pinCe, pinWe, pinOe, pinDrv;
  logic             nCe, nWe, nOe, nDrv;

  assign lastStrobe = (cnt == (isWrite ? WR_LAST : RD_LAST));

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt;
    nxtWrite = isWrite;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          nxtState = ST_SETUP;
          nxtWrite = reqWrite;
          nxtCnt   = '0;
        end
      end
      ST_SETUP: begin
        nxtState = ST_STROBE;
        nxtCnt   = '0;
      end
      ST_STROBE: begin
        if (lastStrobe) begin
          nxtState = ST_RECOVER;
          nxtCnt   = '0;
        end else begin
          nxtCnt = cnt + CNT_W'(1);
        end
      end
      ST_RECOVER: begin
        if (cnt == TURN_LAST) begin
          nxtState = ST_IDLE;
          nxtCnt   = '0;
        end else begin
          nxtCnt = cnt + CNT_W'(1);
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  // pin strobes decoded from the next state so the registered pins are glitch free
  always_comb begin
    nCe  = (nxtState == ST_SETUP) || (nxtState == ST_STROBE);
    nWe  = (nxtState == ST_STROBE) && nxtWrite;
    nOe  = (nxtState == ST_STROBE) && !nxtWrite;
    nDrv = nxtWrite && (((nxtState == ST_STROBE) && (nxtCnt >= HZ_AT)) ||
                        ((nxtState == ST_RECOVER) && (nxtCnt == '0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      pinCe   <= 1'b0;
      pinWe   <= 1'b0;
      pinOe   <= 1'b0;
      pinDrv  <= 1'b0;
    end else begin
      state   <= nxtState;
      cnt     <= nxtCnt;
      isWrite <= nxtWrite;
      pinCe   <= nCe;
      pinWe   <= nWe;
      pinOe   <= nOe;
      pinDrv  <= nDrv;
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctl.load    = (state == ST_IDLE) && reqValid;
    ctl.capture = (state == ST_STROBE) && !isWrite && lastStrobe;
    ctl.ceOn    = pinCe;
    ctl.weOn    = pinWe;
    ctl.oeOn    = pinOe;
    ctl.drvOn   = pinDrv;
  end

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              validReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= '0;
      wdataReg <= '0;
    end else if (ctl.load) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdataReg <= '0;
      validReg <= 1'b0;
    end else begin
      validReg <= ctl.capture;
      if (ctl.capture) rdataReg <= memDin;
    end
  end

  assign rspValid  = validReg;
  assign rspData   = rdataReg;
  assign memAddr   = addrReg;
  assign memDout   = wdataReg;
  assign memDoutEn = ctl.drvOn;
  assign memCe1N   = !ctl.ceOn;
  assign memCe2    = ctl.ceOn;
  assign memOeN    = !ctl.oeOn;
  assign memWeN    = !ctl.weOn;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AW_NS       = 12,
  parameter int T_PWE_NS      = 10,
  parameter int T_SD_NS       = 8,
  parameter int T_HZWE_NS     = 7,
  parameter int T_AA_NS       = 15,
  parameter int T_DOE_NS      = 7,
  parameter int TURNAROUND    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memDoutEn,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN
);

  localparam int AW_CYC  = nsToCycles(T_AW_NS, CLK_PERIOD_NS);
  localparam int PWE_CYC = nsToCycles(T_PWE_NS, CLK_PERIOD_NS);
  localparam int SD_CYC  = nsToCycles(T_SD_NS, CLK_PERIOD_NS);
  localparam int HZ_CYC  = nsToCycles(T_HZWE_NS, CLK_PERIOD_NS);
  localparam int AA_CYC  = nsToCycles(T_AA_NS, CLK_PERIOD_NS);
  localparam int DOE_CYC = nsToCycles(T_DOE_NS, CLK_PERIOD_NS);
  // the setup cycle already counts toward address-to-write-end and address access
  localparam int WR_CYC  = maxOf(maxOf(PWE_CYC, AW_CYC - 1), HZ_CYC + SD_CYC);
  localparam int RD_CYC  = maxOf(maxOf(AA_CYC - 1, DOE_CYC), 1);
  localparam int CNT_W   = $clog2(maxOf(maxOf(WR_CYC, RD_CYC), TURNAROUND) + 1);

  seqCtl_t ctl;

  sram_strobe_seq #(
    .WR_CYC  (WR_CYC),
    .RD_CYC  (RD_CYC),
    .HZ_CYC  (HZ_CYC),
    .TURN_CYC(TURNAROUND),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ctl     (ctl)
  );

  sram_strobe_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .rspValid (rspValid),
    .rspData  (rspData),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .memCe1N  (memCe1N),
    .memCe2   (memCe2),
    .memOeN   (memOeN),
    .memWeN   (memWeN)
  );

endmodule

// File: rtl/sram_strobe_checker.sv
module sram_strobe_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int HZ_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoutEn,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memOeN,
  input logic              memWeN
);

  assert_cs_polarity_R2: assert property (@(posedge clk) disable iff (rst)
    memCe1N == !memCe2);

  assert_we_oe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(!memWeN && !memOeN));

  assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (rst)
    (!memWeN || !memOeN) |-> (!memCe1N && memCe2));

  assert_drv_vs_oe_R5: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> memOeN);

  if (HZ_CYC > 0) begin : g_hz
    assert_drv_late_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(memWeN) |-> !memDoutEn);
  end

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (memDoutEn && $past(memDoutEn)) |-> $stable(memDout));

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!memCe1N && !$past(memCe1N)) |-> $stable(memAddr));

  assert_rsp_after_oe_R6: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $rose(memOeN));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCe1N && memWeN && memOeN && !memDoutEn && !rspValid));

endmodule

bind sram_strobe_ctrl sram_strobe_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .HZ_CYC(HZ_CYC)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .memAddr  (memAddr),
  .memDout  (memDout),
  .memDoutEn(memDoutEn),
  .memCe1N  (memCe1N),
  .memCe2   (memCe2),
  .memOeN   (memOeN),
  .memWeN   (memWeN)
);

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

  localparam int PERIOD   = 10;
  // expected counts from the requirements at default timing
  localparam int WR_LEN   = 2;
  localparam int RD_LEN   = 1;
  localparam int HZ_LEN   = 1;
  localparam int TURN_LEN = 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqWrite;
  logic [16:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        reqReady, rspValid;
  logic [7:0]  rspData;
  logic [16:0] memAddr;
  logic [7:0]  memDout, memDin;
  logic        memDoutEn, memCe1N, memCe2, memOeN, memWeN;

  always #(PERIOD / 2) clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memDout(memDout), .memDin(memDin), .memDoutEn(memDoutEn),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN)
  );

  typedef struct {
    bit          ce, we, oe, drv, rv, rdy, wrTx;
    logic [16:0] addr;
    logic [7:0]  wd, rd;
    string       tag;
  } vec_t;

  vec_t        expQ[$];
  logic [7:0]  refMem[int];
  logic [7:0]  benchMem[int];
  int          vectors = 0;
  int          misses  = 0;
  logic [16:0] lastAddr;

  bit          opWr[$];
  logic [16:0] opAddr[$];
  logic [7:0]  opData[$];
  int          opGap[$];
  bit          opAbort[$];

  logic [7:0]  pend;
  logic [16:0] pendAddr;
  bit          pendOk = 0;

  function automatic logic [7:0] memDefault(input logic [16:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic vec_t idleVec(input string tag);
    vec_t v;
    v = '{ce: 0, we: 0, oe: 0, drv: 0, rv: 0, rdy: 1, wrTx: 0,
          addr: lastAddr, wd: 8'h00, rd: 8'h00, tag: tag};
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareVec(input vec_t e);
    vectors++;
    chk(e.tag, "chip select", int'(memCe2), int'(e.ce));
    chk("R2", "enable polarity", int'(memCe1N), int'(!memCe2));
    chk("R3", "WE and OE overlap", int'(!memWeN && !memOeN), 0);
    chk(e.tag, "write enable", int'(!memWeN), int'(e.we));
    chk(e.tag, "output enable", int'(!memOeN), int'(e.oe));
    chk("R5", "driver enable", int'(memDoutEn), int'(e.drv));
    if (e.drv) chk("R5", "driven data", int'(memDout), int'(e.wd));
    chk(e.tag, "ready", int'(reqReady), int'(e.rdy));
    chk("R8", "address", int'(memAddr), int'(e.addr));
    chk(e.wrTx ? "R10" : "R6", "read valid", int'(rspValid), int'(e.rv));
    if (e.rv) chk("R6", "read data", int'(rspData), int'(e.rd));
  endtask

  task automatic respond();
    if (!memWeN && memDoutEn && !memCe1N) begin
      pend = memDout; pendAddr = memAddr; pendOk = 1;
    end else if (memWeN && pendOk) begin
      benchMem[int'(pendAddr)] = pend; pendOk = 0;
    end
    if (!memCe1N && memCe2 && !memOeN && memWeN)
      memDin = benchMem.exists(int'(memAddr)) ? benchMem[int'(memAddr)] : memDefault(memAddr);
    else
      memDin = 8'hEE;
  endtask

  task automatic pushWrite(input logic [16:0] a, input logic [7:0] d);
    vec_t v;
    v = '{ce: 1, we: 0, oe: 0, drv: 0, rv: 0, rdy: 0, wrTx: 1, addr: a, wd: d, rd: 8'h00, tag: "R8"};
    expQ.push_back(v);
    for (int k = 0; k < WR_LEN; k++) begin
      v.we = 1; v.drv = (k >= HZ_LEN); v.tag = "R4";
      expQ.push_back(v);
    end
    for (int j = 0; j < TURN_LEN; j++) begin
      v.ce = 0; v.we = 0; v.drv = (j == 0); v.tag = "R9";
      expQ.push_back(v);
    end
  endtask

  task automatic pushRead(input logic [16:0] a);
    vec_t v;
    logic [7:0] expData;
    expData = refMem.exists(int'(a)) ? refMem[int'(a)] : memDefault(a);
    v = '{ce: 1, we: 0, oe: 0, drv: 0, rv: 0, rdy: 0, wrTx: 0, addr: a, wd: 8'h00, rd: expData, tag: "R8"};
    expQ.push_back(v);
    for (int k = 0; k < RD_LEN; k++) begin
      v.oe = 1; v.tag = "R6";
      expQ.push_back(v);
    end
    for (int j = 0; j < TURN_LEN; j++) begin
      v.ce = 0; v.oe = 0; v.rv = (j == 0); v.tag = "R9";
      expQ.push_back(v);
    end
  endtask

  task automatic addOp(input bit w, input logic [16:0] a, input logic [7:0] d, input int gap, input bit ab);
    opWr.push_back(w); opAddr.push_back(a); opData.push_back(d);
    opGap.push_back(gap); opAbort.push_back(ab);
  endtask

  initial begin
    vec_t e;
    bit   rstPrev, rstNext, done;
    int   opIdx, gapLeft, abortCnt, tail;

    // R4 / R6 scenarios: writes over the address range, including both ends
    for (int i = 0; i < 12; i++)
      addOp(1, 17'((i * 32'h2AAB) % 32'h20000), 8'(i * 29 + 7), (i % 3 == 0) ? 2 : 0, 0);
    addOp(1, 17'h1FFFF, 8'hFF, 0, 0);
    addOp(1, 17'h00100, 8'h3C, 0, 0);
    addOp(1, 17'h00100, 8'hC3, 1, 0);   // overwrite
    addOp(0, 17'h00100, 8'h00, 0, 0);
    addOp(0, 17'h1FFFF, 8'h00, 0, 0);
    for (int i = 11; i >= 0; i--)
      addOp(0, 17'((i * 32'h2AAB) % 32'h20000), 8'h00, (i % 4 == 0) ? 3 : 0, 0);
    addOp(0, 17'h0ABCD, 8'h00, 0, 0);   // never written
    addOp(1, 17'h15555, 8'h77, 0, 1);   // R1: cut short by reset
    addOp(0, 17'h15555, 8'h00, 0, 0);
    addOp(1, 17'h0ABCD, 8'h81, 0, 0);
    addOp(0, 17'h0ABCD, 8'h00, 0, 0);

    rst = 1; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0; memDin = 8'hEE;
    rstPrev = 1; done = 0; opIdx = 0; gapLeft = 0; abortCnt = 0; tail = 0; lastAddr = '0;

    for (int cyc = 0; cyc < 5000 && !done; cyc++) begin
      @(negedge clk);
      if (rstPrev) begin
        expQ.delete(); lastAddr = '0; e = idleVec("R1");
      end else if (expQ.size() > 0) begin
        e = expQ.pop_front();
      end else begin
        e = idleVec("R7");
      end
      compareVec(e);
      respond();

      rstNext = (cyc < 3);
      if (abortCnt > 0) begin
        abortCnt--;
        if (abortCnt == 0) rstNext = 1;
      end
      reqValid = 0;
      if (e.rdy && !rstNext) begin
        if (opIdx < opWr.size()) begin
          if (gapLeft > 0) gapLeft--;
          else begin
            reqValid = 1; reqWrite = opWr[opIdx];
            reqAddr = opAddr[opIdx]; reqWdata = opData[opIdx];
            if (opWr[opIdx]) begin
              pushWrite(opAddr[opIdx], opData[opIdx]);
              if (opAbort[opIdx]) abortCnt = 2;
              else refMem[int'(opAddr[opIdx])] = opData[opIdx];
            end else begin
              pushRead(opAddr[opIdx]);
            end
            lastAddr = opAddr[opIdx];
            gapLeft = opGap[opIdx];
            opIdx++;
          end
        end else begin
          tail++;
          if (tail > 3) done = 1;
        end
      end else if (!e.rdy && !rstNext) begin
        // R7: requests while busy must leave every pin alone
        reqValid = cyc[0]; reqWrite = 1; reqAddr = 17'h1CAFE; reqWdata = 8'h99;
      end
      rst = rstNext;
      rstPrev = rstNext;
    end
    if (!done) begin
      misses++;
      $display("FAIL R7 stimulus did not complete: actual %0d expected %0d", opIdx, opWr.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    misses++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule